// File: doc/BRIEF.md
# External Bus Arbiter with Hold Handshake

This block owns a single external memory bus and shares it among three requesters: a DMA engine (reads and writes), the processor's program/data port and the processor's I/O port. An outside master may also claim the whole bus through a hold request / hold acknowledge pair. Each requester raises a request level together with an address and a write flag. The arbiter grants one requester at a time. Every granted bus cycle runs to a fixed length taken from a parameter: DMA writes and DMA reads have their own lengths. A requester that is not granted sees its wait output high for as long as its request stands.

Long transfers are never run as one burst. Every grant covers one bus cycle, and a new decision is made in the free cycle that follows. This lets the processor and the hold master get in between DMA cycles. A hold request is acknowledged only once no DMA request is pending. While the acknowledge is high no requester drives the bus, and the bus output enable is low, so the pins float. A hold-mode input chooses between two cases: the processor keeps running internally during hold, or its halt output is raised.

Top module: `xbus_arbiter`

## Requirements
- R1: After reset no grant is active, holdAck is 0, cpuHalt is 0 and extOe is 0.
- R2: At most one grant bit is high in any cycle. extOe is high exactly when a grant is active. extAddr and extWe then carry the address and write flag of the granted requester, captured when its grant began. extAddr and extWe are 0 when no grant is active.
- R3: A DMA request beats a processor I/O request, and a processor program/data request also beats an I/O request.
- R4: When DMA and processor program/data requests compete in the same free cycle, the winner is the side that did not take the most recent DMA-or-processor grant. After reset the first such tie goes to DMA.
- R5: A granted cycle lasts exactly DMA_WR_LEN cycles (default 9) for a DMA write (dmaWrite=1), DMA_RD_LEN cycles (default 13) for a DMA read, CPU_LEN cycles (default 2) for the program/data port and IO_LEN cycles (default 4) for the I/O port.
- R6: A grant is never preempted. After a grant ends there is always at least one cycle with no grant before the next grant starts.
- R7: Each wait output equals its request input while that requester is not granted, and is 0 while it is granted.
- R8: With holdReq high, a free cycle with dmaReq high grants DMA. A free cycle with dmaReq low raises holdAck at the next edge. Processor requests are never granted while holdReq is high.
- R9: While holdAck is high no grant is active and extOe is 0, so the external pins are floated.
- R10: holdAck falls at the first edge at which holdReq is sampled low. A new grant can start at the edge after that.
- R11: cpuHalt is high exactly when holdAck is high and holdMode is 1. With holdMode 0, cpuHalt stays low during hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaReq | input | 1 | DMA request level |
| dmaWrite | input | 1 | DMA direction, 1 = write |
| dmaAddr | input | AW | DMA address |
| cpuReq | input | 1 | Processor program/data request |
| cpuWrite | input | 1 | Processor program/data direction |
| cpuAddr | input | AW | Processor program/data address |
| ioReq | input | 1 | Processor I/O request |
| ioWrite | input | 1 | Processor I/O direction |
| ioAddr | input | AW | Processor I/O address |
| holdReq | input | 1 | Outside master requests the bus |
| holdMode | input | 1 | 1 = halt the processor during hold |
| grantDma | output | 1 | DMA owns the current bus cycle |
| grantCpu | output | 1 | Program/data port owns the current bus cycle |
| grantIo | output | 1 | I/O port owns the current bus cycle |
| waitDma | output | 1 | DMA stalled |
| waitCpu | output | 1 | Program/data port stalled |
| waitIo | output | 1 | I/O port stalled |
| holdAck | output | 1 | Bus released to the outside master |
| cpuHalt | output | 1 | Processor halted for hold |
| extOe | output | 1 | External output enable, 0 = pins floated |
| extWe | output | 1 | External write strobe of the granted cycle |
| extAddr | output | AW | External address of the granted cycle |

## Verification
Grants, extOe, extAddr and extWe are registered. They change at the rising edge where the request is seen in a free cycle, so they are visible one cycle after the request is presented. They stay for exactly the requester's cycle length. The wait outputs are combinational and follow the request inputs in the same cycle. holdAck rises at the edge that samples a free cycle with hold requested and no DMA request, and falls at the edge that samples the hold request low. The bench moves a behavioural model at every rising edge. At every falling edge it compares each output with the model, while the inputs are stable, and then applies the next inputs. Separate directed checks measure the run length of each kind of grant.

// File: rtl/xbarb_pkg.sv
package xbarb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_DMA  = 2'd1,
    OWN_CPU  = 2'd2,
    OWN_IO   = 2'd3
  } owner_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   start;
    owner_e who;
  } strobe_t;

endpackage

// File: rtl/xbarb_ctrl.sv
module xbarb_ctrl
  import xbarb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dmaReq,
  input  logic    cpuReq,
  input  logic    ioReq,
  input  logic    holdReq,
  input  logic    holdMode,
  input  logic    lastBeat,
  output owner_e  owner,
  output strobe_t strobe,
  output logic    holdAck,
  output logic    cpuHalt
);

  logic   lastDma;
  logic   takeHold;
  logic   busFree;
  owner_e pick;

  // fixed priority with a toggling tie-break between DMA and program/data
  always_comb begin
    pick = OWN_NONE;
    if (dmaReq && cpuReq) pick = lastDma ? OWN_CPU : OWN_DMA;
    else if (dmaReq)      pick = OWN_DMA;
    else if (cpuReq)      pick = OWN_CPU;
    else if (ioReq)       pick = OWN_IO;
  end

  always_comb begin
    busFree      = (owner == OWN_NONE) && !holdAck;
    strobe.start = 1'b0;
    strobe.who   = OWN_NONE;
    takeHold     = 1'b0;
    if (busFree) begin
      if (holdReq) begin
        // drain pending DMA before releasing the bus
        if (dmaReq) begin
          strobe.start = 1'b1;
          strobe.who   = OWN_DMA;
        end else begin
          takeHold = 1'b1;
        end
      end else if (pick != OWN_NONE) begin
        strobe.start = 1'b1;
        strobe.who   = pick;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner   <= OWN_NONE;
      holdAck <= 1'b0;
      lastDma <= 1'b0;
    end else begin
      if (strobe.start) begin
        owner <= strobe.who;
        if (strobe.who == OWN_DMA)      lastDma <= 1'b1;
        else if (strobe.who == OWN_CPU) lastDma <= 1'b0;
      end else if (owner != OWN_NONE && lastBeat) begin
        owner <= OWN_NONE;
      end
      if (takeHold)                holdAck <= 1'b1;
      else if (holdAck && !holdReq) holdAck <= 1'b0;
    end
  end

  assign cpuHalt = holdAck && holdMode;

  // R6: a running cycle keeps its owner until its last beat
  a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rstN)
    (owner != OWN_NONE && !lastBeat) |=> (owner == $past(owner)));

  // R6: the cycle after a last beat is always free
  a_r6_idle_gap: assert property (@(posedge clk) disable iff (!rstN)
    (owner != OWN_NONE && lastBeat) |=> (owner == OWN_NONE));

  // R8: acknowledge only after a cycle with hold asked and no DMA pending
  a_r8_drain_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> ($past(holdReq) && !$past(dmaReq)));

  // R9: nobody owns the bus during hold
  a_r9_idle_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (owner == OWN_NONE));

  // R10: release follows a sampled low hold request
  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && !holdReq) |=> !holdAck);

endmodule

// File: rtl/xbarb_dpath.sv
module xbarb_dpath
  import xbarb_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DMA_WR_LEN = 9,
  parameter int DMA_RD_LEN = 13,
  parameter int CPU_LEN    = 2,
  parameter int IO_LEN     = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  owner_e        owner,
  input  logic          dmaWrite,
  input  logic [AW-1:0] dmaAddr,
  input  logic          cpuWrite,
  input  logic [AW-1:0] cpuAddr,
  input  logic          ioWrite,
  input  logic [AW-1:0] ioAddr,
  output logic          lastBeat,
  output logic          grantDma,
  output logic          grantCpu,
  output logic          grantIo,
  output logic          extOe,
  output logic          extWe,
  output logic [AW-1:0] extAddr
);

  localparam int MaxA   = (DMA_WR_LEN > DMA_RD_LEN) ? DMA_WR_LEN : DMA_RD_LEN;
  localparam int MaxB   = (CPU_LEN > IO_LEN) ? CPU_LEN : IO_LEN;
  localparam int MaxLen = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int CW     = $clog2(MaxLen + 1);

  logic [CW-1:0] beatsLeft;
  logic [CW-1:0] loadVal;
  logic          weQ;
  logic [AW-1:0] addrQ;
  logic          weNext;
  logic [AW-1:0] addrNext;

  always_comb begin
    loadVal  = '0;
    weNext   = 1'b0;
    addrNext = '0;
    case (strobe.who)
      OWN_DMA: begin
        loadVal  = dmaWrite ? CW'(DMA_WR_LEN - 1) : CW'(DMA_RD_LEN - 1);
        weNext   = dmaWrite;
        addrNext = dmaAddr;
      end
      OWN_CPU: begin
        loadVal  = CW'(CPU_LEN - 1);
        weNext   = cpuWrite;
        addrNext = cpuAddr;
      end
      OWN_IO: begin
        loadVal  = CW'(IO_LEN - 1);
        weNext   = ioWrite;
        addrNext = ioAddr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatsLeft <= '0;
      weQ       <= 1'b0;
      addrQ     <= '0;
    end else if (strobe.start) begin
      beatsLeft <= loadVal;
      weQ       <= weNext;
      addrQ     <= addrNext;
    end else if (beatsLeft != '0) begin
      beatsLeft <= beatsLeft - 1'b1;
    end
  end

  assign lastBeat = (beatsLeft == '0);
  assign grantDma = (owner == OWN_DMA);
  assign grantCpu = (owner == OWN_CPU);
  assign grantIo  = (owner == OWN_IO);
  assign extOe    = (owner != OWN_NONE);
  assign extWe    = extOe && weQ;
  assign extAddr  = extOe ? addrQ : '0;

  // R5: address and direction hold steady through a granted cycle
  a_r5_stable_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (extOe && !lastBeat) |=> ($stable(extAddr) && $stable(extWe)));

endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
  import xbarb_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DMA_WR_LEN = 9,
  parameter int DMA_RD_LEN = 13,
  parameter int CPU_LEN    = 2,
  parameter int IO_LEN     = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dmaReq,
  input  logic          dmaWrite,
  input  logic [AW-1:0] dmaAddr,
  input  logic          cpuReq,
  input  logic          cpuWrite,
  input  logic [AW-1:0] cpuAddr,
  input  logic          ioReq,
  input  logic          ioWrite,
  input  logic [AW-1:0] ioAddr,
  input  logic          holdReq,
  input  logic          holdMode,
  output logic          grantDma,
  output logic          grantCpu,
  output logic          grantIo,
  output logic          waitDma,
  output logic          waitCpu,
  output logic          waitIo,
  output logic          holdAck,
  output logic          cpuHalt,
  output logic          extOe,
  output logic          extWe,
  output logic [AW-1:0] extAddr
);

  owner_e  owner;
  strobe_t strobe;
  logic    lastBeat;

  xbarb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dmaReq   (dmaReq),
    .cpuReq   (cpuReq),
    .ioReq    (ioReq),
    .holdReq  (holdReq),
    .holdMode (holdMode),
    .lastBeat (lastBeat),
    .owner    (owner),
    .strobe   (strobe),
    .holdAck  (holdAck),
    .cpuHalt  (cpuHalt)
  );

  xbarb_dpath #(
    .AW         (AW),
    .DMA_WR_LEN (DMA_WR_LEN),
    .DMA_RD_LEN (DMA_RD_LEN),
    .CPU_LEN    (CPU_LEN),
    .IO_LEN     (IO_LEN)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .owner    (owner),
    .dmaWrite (dmaWrite),
    .dmaAddr  (dmaAddr),
    .cpuWrite (cpuWrite),
    .cpuAddr  (cpuAddr),
    .ioWrite  (ioWrite),
    .ioAddr   (ioAddr),
    .lastBeat (lastBeat),
    .grantDma (grantDma),
    .grantCpu (grantCpu),
    .grantIo  (grantIo),
    .extOe    (extOe),
    .extWe    (extWe),
    .extAddr  (extAddr)
  );

  // stall whoever asks but does not own the bus
  assign waitDma = dmaReq && !grantDma;
  assign waitCpu = cpuReq && !grantCpu;
  assign waitIo  = ioReq  && !grantIo;

  // R2: a single owner at a time
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantDma, grantCpu, grantIo}));

  // R8: processor ports never win while hold is being requested
  a_r8_no_cpu_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(grantCpu) || $rose(grantIo)) |-> !$past(holdReq));

endmodule

// File: tb/sim_xbus_arbiter.sv
`timescale 1ns/1ps
module sim_xbus_arbiter;

  localparam int AW = 16;
  localparam int WrLen = 9, RdLen = 13, CpLen = 2, IoLen = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaReq = 0, dmaWrite = 0, cpuReq = 0, cpuWrite = 0, ioReq = 0, ioWrite = 0;
  logic holdReq = 0, holdMode = 0;
  logic [AW-1:0] dmaAddr = '0, cpuAddr = '0, ioAddr = '0;
  logic grantDma, grantCpu, grantIo, waitDma, waitCpu, waitIo;
  logic holdAck, cpuHalt, extOe, extWe;
  logic [AW-1:0] extAddr;

  always #2 clk = ~clk;

  xbus_arbiter #(.AW(AW)) u0 (
    .clk(clk), .rstN(rstN),
    .dmaReq(dmaReq), .dmaWrite(dmaWrite), .dmaAddr(dmaAddr),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .ioReq(ioReq), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .holdReq(holdReq), .holdMode(holdMode),
    .grantDma(grantDma), .grantCpu(grantCpu), .grantIo(grantIo),
    .waitDma(waitDma), .waitCpu(waitCpu), .waitIo(waitIo),
    .holdAck(holdAck), .cpuHalt(cpuHalt),
    .extOe(extOe), .extWe(extWe), .extAddr(extAddr)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural model ----------------
  int mOwner = 0;        // 0 none, 1 dma, 2 cpu, 3 io
  int mLeft = 0;
  bit mLastDma = 0;
  bit mHold = 0;
  bit mWe = 0;
  int mAddr = 0;

  task automatic mStart(int who);
    mOwner = who;
    case (who)
      1: begin mLeft = dmaWrite ? WrLen : RdLen; mWe = dmaWrite; mAddr = dmaAddr; mLastDma = 1; end
      2: begin mLeft = CpLen; mWe = cpuWrite; mAddr = cpuAddr; mLastDma = 0; end
      default: begin mLeft = IoLen; mWe = ioWrite; mAddr = ioAddr; end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mOwner = 0; mLeft = 0; mLastDma = 0; mHold = 0; mWe = 0; mAddr = 0;
    end else if (mOwner != 0) begin
      if (mLeft == 1) mOwner = 0;
      else mLeft--;
    end else if (mHold) begin
      if (!holdReq) mHold = 0;
    end else if (holdReq) begin
      if (dmaReq) mStart(1);
      else mHold = 1;
    end else if (dmaReq && cpuReq) begin
      mStart(mLastDma ? 2 : 1);
    end else if (dmaReq) mStart(1);
    else if (cpuReq) mStart(2);
    else if (ioReq) mStart(3);
  end

  // run-length capture for directed checks
  int runLen = 0, lastRun = 0, runOwner = 0;
  bit sawAckWithDma = 0;

  task automatic compareAll();
    int g;
    g = {29'd0, grantIo, grantCpu, grantDma};
    check("R2 R3 R4 R6 R8 grant vector", g,
          (mOwner == 1) ? 1 : (mOwner == 2) ? 2 : (mOwner == 3) ? 4 : 0);
    check("R7 waitDma", int'(waitDma), int'(dmaReq && mOwner != 1));
    check("R7 waitCpu", int'(waitCpu), int'(cpuReq && mOwner != 2));
    check("R7 waitIo",  int'(waitIo),  int'(ioReq && mOwner != 3));
    check("R8 R10 holdAck", int'(holdAck), int'(mHold));
    check("R11 cpuHalt", int'(cpuHalt), int'(mHold && holdMode));
    check("R2 R9 extOe", int'(extOe), int'(mOwner != 0));
    check("R2 extWe", int'(extWe), int'(mOwner != 0 && mWe));
    check("R2 extAddr", int'(extAddr), (mOwner != 0) ? mAddr : 0);
    if (holdAck && dmaReq && !grantDma && mOwner == 0) sawAckWithDma = 1;
    if (g != 0) begin
      if (runLen == 0) runOwner = g;
      runLen++;
    end else if (runLen > 0) begin
      lastRun = runLen; runLen = 0;
    end
  endtask

  // one cycle: compare at falling edge, then apply the next inputs
  task automatic step(bit d, bit dw, bit c, bit cw, bit i, bit iw, bit h, bit hm);
    @(negedge clk);
    if (rstN) compareAll();
    dmaReq = d; dmaWrite = dw; cpuReq = c; cpuWrite = cw; ioReq = i; ioWrite = iw;
    holdReq = h; holdMode = hm;
    dmaAddr = dmaAddr + 16'h0101; cpuAddr = cpuAddr + 16'h0011; ioAddr = ioAddr + 16'h0003;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0,0,0,0,0,0,0,0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 grants after reset", int'({grantDma, grantCpu, grantIo}), 0);
    check("R1 holdAck after reset", int'(holdAck), 0);
    check("R1 extOe after reset", int'(extOe), 0);
    check("R1 cpuHalt after reset", int'(cpuHalt), 0);
    rstN = 1'b1;
    idle(3);

    // R5: DMA write length
    step(1,1,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    idle(16);
    check("R5 dma write run", lastRun, WrLen);
    // R5: DMA read length
    step(1,0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    idle(18);
    check("R5 dma read run", lastRun, RdLen);
    // R5: program/data and io lengths
    step(0,0,1,1,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    idle(5);
    check("R5 cpu run", lastRun, CpLen);
    step(0,0,0,0,1,0,0,0);
    step(0,0,0,0,0,0,0,0);
    idle(7);
    check("R5 io run", lastRun, IoLen);

    // R3/R4: contention held steady for a while (model compares every cycle)
    for (int k = 0; k < 80; k++) step(1, k[0], 1, 0, 1, 1, 0, 0);
    for (int k = 0; k < 30; k++) step(0, 0, 1, 1, 1, 0, 0, 0);
    idle(4);

    // R8: hold with DMA pending must not be acknowledged
    sawAckWithDma = 0;
    for (int k = 0; k < 40; k++) step(1, 1, 1, 0, 0, 0, 1, 1);
    check("R8 no ack while dma pending", int'(sawAckWithDma), 0);
    check("R8 ack still low", int'(holdAck), 0);
    // drain, then hold with halt mode
    for (int k = 0; k < 16; k++) step(0, 0, 1, 0, 1, 0, 1, 1);
    check("R9 ack up, bus floated", int'(holdAck && !extOe), 1);
    check("R11 halt in mode 1", int'(cpuHalt), 1);
    step(0, 0, 1, 0, 1, 0, 1, 0);
    step(0, 0, 1, 0, 1, 0, 1, 0);
    check("R11 no halt in mode 0", int'(cpuHalt), 0);
    // R10: release
    step(0, 0, 1, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0, 0);
    check("R10 ack dropped", int'(holdAck), 0);
    step(0, 0, 1, 0, 1, 0, 0, 0);
    check("R10 grant resumed", int'(grantCpu), 1);
    idle(4);

    // random traffic with occasional hold windows
    begin
      bit h = 0;
      bit hm = 0;
      for (int k = 0; k < 6000; k++) begin
        if (($urandom % 64) == 0) h = ~h;
        if (($urandom % 128) == 0) hm = ~hm;
        step(($urandom % 3) != 0, $urandom % 2, ($urandom % 2) == 0, $urandom % 2,
             ($urandom % 3) == 0, $urandom % 2, h, hm);
      end
    end
    idle(20);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule